// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter units. Each unit keeps a low and a high count byte and advances either on machine-cycle ticks (timer) or on falling edges of its own count pin (counter). A per-unit mode field picks one of four ways to count: a 13-bit counter with a 5-bit prescaler, a 16-bit counter, an 8-bit counter with automatic reload, and a split mode. In split mode, unit 0 becomes two independent 8-bit counters, and its high byte borrows unit 1's run control and overflow flag.

A unit counts while its run bit is set, or while its gate bit is set and its gate pin is high. An overflow sets a sticky per-unit flag. Every overflow of unit 1's own counter also gives a one-cycle pulse that can serve as a serial bit clock. Software reaches the four count bytes, the mode byte and the control byte through a plain synchronous write port and a combinational read port. Address decoding for the wider bus and interrupt handling are left to neighbouring logic.

Top module: `tmr_pair`

## Requirements
- R1: After reset all count bytes, the mode byte, the run bits, both flags and `baud_tick` are zero.
- R2: Mode 0 (field value 0): each step increments the low byte. When its low 5 bits are all ones, the step clears the whole low byte and increments the high byte. A high byte that wraps from 0xFF sets the unit's flag.
- R3: Mode 1 (field value 1): high and low bytes form one 16-bit counter. Wrapping from 0xFFFF sets the flag.
- R4: Mode 2 (field value 2): only the low byte counts. A step taken at 0xFF loads the low byte from the high byte and sets the flag.
- R5: Mode 3 (field value 3) on unit 0: the low byte is an 8-bit counter with unit 0's controls and flag 0. The high byte counts ticks whenever run bit 1 is set, or gate 1 is set and `gate_pin[1]` is high, and its wrap sets flag 1. That wrap does not pulse `baud_tick`.
- R6: Mode 3 on unit 1: both unit 1 bytes hold their values.
- R7: A unit is enabled when its run bit is 1, or its gate bit is 1 and its gate pin is high. A disabled unit does not count.
- R8: With the counter bit set, a unit steps once per falling edge of its count pin (pin high in the previous cycle, low now), and `tick_en` has no effect. With the counter bit clear, it steps once per cycle with `tick_en` high.
- R9: Each wrap of unit 1's own counter drives `baud_tick` high for exactly one cycle, in the cycle after the wrapping edge.
- R10: A write to a count byte replaces that byte in place of any step in the same cycle. A flag set by overflow wins over a control write that clears it in the same cycle.
- R11: Select codes: 0 low byte 0, 1 high byte 0, 2 low byte 1, 3 high byte 1, 4 mode, 5 control. Mode byte: unit u uses bits [4u+3:4u] = {gate, counter, mode[1:0]}. Control byte: bit 0 run 0, bit 1 run 1, bit 4 flag 0, bit 5 flag 1. Other control bits read 0. Selects 6 and 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Machine-cycle tick qualifier for timer mode |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | External gate pins, one per unit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data, combinational from `rd_sel` |
| ovf_flag | output | 2 | Sticky overflow flags, one per unit |
| baud_tick | output | 1 | One-cycle pulse per unit 1 overflow |

## Verification
The assertions assume that the count and gate pins are already synchronous to `clk`. They also assume that a count pin holds each level for at least one full cycle, so that a falling edge is always seen as one high sample followed by one low sample. The stimulus changes pins and register writes only on the falling clock edge. It holds each pin level for whole cycles and keeps `tick_en` low while it sets up the registers, so that every step window it checks is exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_13B    = 2'd0,
    TM_16B    = 2'd1,
    TM_RELOAD = 2'd2,
    TM_SPLIT  = 2'd3
  } tmr_mode_e;

  localparam int NUM_UNITS = 2;
  localparam int SEL_W     = 3;

  localparam logic [SEL_W-1:0] SEL_LO0  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_HI0  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LO1  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_HI1  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_MODE = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd5;

  localparam int CTRL_RUN_LSB  = 0;
  localparam int CTRL_FLAG_LSB = 4;

  typedef struct packed {
    logic      gate;
    logic      counter;
    tmr_mode_e mode;
  } unit_cfg_t;
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pin;
  end

  assign fall = prev_q & ~pin;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              step,
  input  logic              step_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf,
  output logic              ovf_hi
);
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_n, hi_n, hi_split_n;
  logic              ovf_main, split_wrap;
  logic [WIDE_W-1:0] wide_inc;

  assign wide_inc = {hi, lo} + 1'b1;

  always_comb begin
    lo_n     = lo;
    hi_n     = hi;
    ovf_main = 1'b0;
    if (step) begin
      unique case (mode)
        TM_13B: begin
          if (lo[PRE_W-1:0] == '1) begin
            lo_n     = '0;
            hi_n     = hi + 1'b1;
            ovf_main = (hi == '1);
          end else begin
            lo_n = lo + 1'b1;
          end
        end
        TM_16B: begin
          {hi_n, lo_n} = wide_inc;
          ovf_main     = ({hi, lo} == '1);
        end
        TM_RELOAD: begin
          if (lo == '1) begin
            lo_n     = hi;
            ovf_main = 1'b1;
          end else begin
            lo_n = lo + 1'b1;
          end
        end
        TM_SPLIT: begin
          if (SPLIT_OK) begin
            lo_n     = lo + 1'b1;
            ovf_main = (lo == '1);
          end
        end
        default: ;
      endcase
    end
  end

  generate
    if (SPLIT_OK) begin : g_split
      always_comb begin
        hi_split_n = hi_n;
        split_wrap = 1'b0;
        if (mode == TM_SPLIT && step_hi) begin
          hi_split_n = hi + 1'b1;
          split_wrap = (hi == '1);
        end
      end
    end else begin : g_nosplit
      always_comb begin
        hi_split_n = hi_n;
        split_wrap = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wr_data : lo_n;
      hi <= wr_hi ? wr_data : hi_split_n;
    end
  end

  assign ovf    = ovf_main;
  assign ovf_hi = split_wrap;

  // R4: a wrap in reload mode loads the high byte into the low byte
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == TM_RELOAD && lo == '1 && !wr_lo) |=> (lo == $past(hi)));

  // R2: high byte moves in mode 0 only when the prescaler wraps
  p_prescale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_13B && lo[PRE_W-1:0] != '1 && !wr_hi) |=> $stable(hi));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic [1:0]        ovf_flag,
  output logic              baud_tick
);
  localparam int CFG_W = $bits(unit_cfg_t);

  logic [BYTE_W-1:0]    mode_q;
  logic [NUM_UNITS-1:0] run_q, flag_q, flag_n;
  logic                 baud_q;
  logic [NUM_UNITS-1:0] fall, enable, step, ovf, ovf_hi;
  logic [NUM_UNITS-1:0] wr_lo, wr_hi;
  logic [BYTE_W-1:0]    lo_w [NUM_UNITS];
  logic [BYTE_W-1:0]    hi_w [NUM_UNITS];
  unit_cfg_t            cfg  [NUM_UNITS];
  logic                 split_step;
  logic                 wr_mode, wr_ctrl;

  tmr_pin_edge #(.N(NUM_UNITS)) edge_i (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cnt_pin),
    .fall (fall)
  );

  assign wr_mode = wr_en && (wr_sel == SEL_MODE);
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

  // high byte of unit 0 in split mode runs on unit 1's enable and ticks
  assign split_step = enable[1] & tick_en;

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      assign cfg[u]    = unit_cfg_t'(mode_q[u*CFG_W +: CFG_W]);
      assign enable[u] = run_q[u] | (cfg[u].gate & gate_pin[u]);
      assign step[u]   = enable[u] & (cfg[u].counter ? fall[u] : tick_en);
      assign wr_lo[u]  = wr_en && (wr_sel == SEL_W'(2*u));
      assign wr_hi[u]  = wr_en && (wr_sel == SEL_W'(2*u + 1));

      tmr_core #(
        .BYTE_W  (BYTE_W),
        .PRE_W   (PRE_W),
        .SPLIT_OK(u == 0)
      ) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (cfg[u].mode),
        .step   (step[u]),
        .step_hi((u == 0) ? split_step : 1'b0),
        .wr_lo  (wr_lo[u]),
        .wr_hi  (wr_hi[u]),
        .wr_data(wr_data),
        .lo     (lo_w[u]),
        .hi     (hi_w[u]),
        .ovf    (ovf[u]),
        .ovf_hi (ovf_hi[u])
      );
    end
  endgenerate

  always_comb begin
    flag_n = flag_q;
    if (wr_ctrl) flag_n = wr_data[CTRL_FLAG_LSB +: NUM_UNITS];
    if (ovf[0]) flag_n[0] = 1'b1;
    if (ovf[1] || ovf_hi[0]) flag_n[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      baud_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wr_data;
      if (wr_ctrl) run_q  <= wr_data[CTRL_RUN_LSB +: NUM_UNITS];
      flag_q <= flag_n;
      baud_q <= ovf[1];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      SEL_LO0:  rd_data = lo_w[0];
      SEL_HI0:  rd_data = hi_w[0];
      SEL_LO1:  rd_data = lo_w[1];
      SEL_HI1:  rd_data = hi_w[1];
      SEL_MODE: rd_data = mode_q;
      SEL_CTRL: begin
        rd_data[CTRL_RUN_LSB  +: NUM_UNITS] = run_q;
        rd_data[CTRL_FLAG_LSB +: NUM_UNITS] = flag_q;
      end
      default:  rd_data = '0;
    endcase
  end

  assign ovf_flag  = flag_q;
  assign baud_tick = baud_q;

  // R10: overflow sets the flag even against a clearing write
  p_flag_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[0] |=> ovf_flag[0]);

  // R10: a write to the low byte wins over a step
  p_wr_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_LO0) |=> (lo_w[0] == $past(wr_data)));

  // R9: the serial clock pulse always comes with flag 1 set
  p_baud_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> ovf_flag[1]);

  // R6: unit 1 holds in mode 3
  p_t1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1].mode == TM_SPLIT && !wr_lo[1] && !wr_hi[1])
      |=> ($stable(lo_w[1]) && $stable(hi_w[1])));

  // R7: a disabled unit's low byte does not move
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !(cfg[0].gate && gate_pin[0]) && !wr_lo[0]) |=> $stable(lo_w[0]));

  // R8: in counter mode the low byte moves only on a falling pin edge
  p_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0].counter && !(prev_low_seen()) && !wr_lo[0]) |=> $stable(lo_w[0]));

  function automatic logic prev_low_seen();
    return fall[0];
  endfunction
endmodule

// File: tb/tmr_pair_tb_top.sv
`timescale 1ns/1ps
module tmr_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [1:0] ovf_flag;
  logic       baud_tick;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_pair dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ovf_flag(ovf_flag), .baud_tick(baud_tick)
  );

  // vector: mode, lo0, hi0, ticks, exp lo0, exp hi0, exp flag0
  localparam int NV = 7;
  localparam logic [55:0] VEC [NV] = '{
    {8'h01, 8'hFE, 8'h12, 8'd3, 8'h01, 8'h13, 8'h00},
    {8'h01, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 8'h01},
    {8'h00, 8'h1E, 8'h05, 8'd3, 8'h01, 8'h06, 8'h00},
    {8'h00, 8'h1F, 8'hFF, 8'd1, 8'h00, 8'h00, 8'h01},
    {8'h02, 8'hFE, 8'h80, 8'd3, 8'h81, 8'h80, 8'h01},
    {8'h02, 8'h10, 8'hAA, 8'd5, 8'h15, 8'hAA, 8'h00},
    {8'h03, 8'hFF, 8'h40, 8'd2, 8'h01, 8'h40, 8'h01}
  };

  function automatic string req_of(input logic [7:0] m);
    case (m[1:0])
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic tick(input int n, output int b);
    b = 0;
    @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (baud_tick) b++;
    end
    tick_en = 1'b0;
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      chk("R1", "reset byte", v, 8'h00);
    end
    chk("R1", "flags", {6'd0, ovf_flag}, 8'h00);
    chk("R1", "baud", {7'd0, baud_tick}, 8'h00);

    // table walk: unit 0 in each mode
    for (int k = 0; k < NV; k++) begin
      wr(3'd5, 8'h00);
      wr(3'd4, VEC[k][55:48]);
      wr(3'd0, VEC[k][47:40]);
      wr(3'd1, VEC[k][39:32]);
      wr(3'd5, 8'h01);
      tick(int'(VEC[k][31:24]), b);
      rd(3'd0, v); chk(req_of(VEC[k][55:48]), "lo0", v, VEC[k][23:16]);
      rd(3'd1, v); chk(req_of(VEC[k][55:48]), "hi0", v, VEC[k][15:8]);
      chk(req_of(VEC[k][55:48]), "flag0", {7'd0, ovf_flag[0]}, VEC[k][7:0]);
    end

    // R7: gate control
    wr(3'd5, 8'h00); wr(3'd4, 8'h09); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    gate_pin[0] = 1'b0;
    tick(4, b);
    rd(3'd0, v); chk("R7", "gate low holds", v, 8'h00);
    gate_pin[0] = 1'b1;
    tick(4, b);
    rd(3'd0, v); chk("R7", "gate high counts", v, 8'h04);
    gate_pin[0] = 1'b0;

    // R8: counter mode on pin falls, tick_en ignored
    wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd5, 8'h01);
    tick(5, b);
    rd(3'd0, v); chk("R8", "ticks ignored", v, 8'h00);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); cnt_pin[0] = 1'b0;
      @(negedge clk); cnt_pin[0] = 1'b1;
    end
    @(negedge clk);
    rd(3'd0, v); chk("R8", "edge count", v, 8'h03);

    // R5: split high byte on unit 1 controls
    wr(3'd5, 8'h00); wr(3'd4, 8'h13);
    wr(3'd0, 8'h00); wr(3'd1, 8'hFE); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd5, 8'h02);
    tick(2, b);
    rd(3'd1, v); chk("R5", "hi0 split", v, 8'h00);
    rd(3'd0, v); chk("R5", "lo0 idle", v, 8'h00);
    chk("R5", "flags", {6'd0, ovf_flag}, 8'h02);
    rd(3'd2, v); chk("R5", "lo1 runs", v, 8'h02);
    chk("R5", "no baud from hi0", 8'(b), 8'h00);

    // R6: unit 1 mode 3 holds
    wr(3'd5, 8'h00); wr(3'd4, 8'h30); wr(3'd2, 8'h05); wr(3'd3, 8'h07);
    wr(3'd5, 8'h02);
    tick(4, b);
    rd(3'd2, v); chk("R6", "lo1 held", v, 8'h05);
    rd(3'd3, v); chk("R6", "hi1 held", v, 8'h07);

    // R9: baud pulses from unit 1 reload mode
    wr(3'd5, 8'h00); wr(3'd4, 8'h20); wr(3'd2, 8'hFE); wr(3'd3, 8'hFC);
    wr(3'd5, 8'h02);
    tick(10, b);
    chk("R9", "baud pulses", 8'(b), 8'h03);
    rd(3'd2, v); chk("R9", "lo1 after reloads", v, 8'hFC);

    // R10: write beats step
    wr(3'd5, 8'h00); wr(3'd4, 8'h01); wr(3'd0, 8'h10); wr(3'd5, 8'h01);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h55;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(3'd0, v); chk("R10", "write priority", v, 8'h55);

    // R10: overflow beats flag clear
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'h01;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    chk("R10", "flag set wins", {7'd0, ovf_flag[0]}, 8'h01);

    // R11: register map corners
    wr(3'd5, 8'hFF);
    rd(3'd5, v); chk("R11", "ctrl readback", v, 8'h33);
    chk("R11", "flags from ctrl", {6'd0, ovf_flag}, 8'h03);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h21);
    wr(3'd7, 8'hAA);
    rd(3'd4, v); chk("R11", "mode kept", v, 8'h21);
    rd(3'd6, v); chk("R11", "sel 6 zero", v, 8'h00);
    rd(3'd7, v); chk("R11", "sel 7 zero", v, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule